// File: doc/BRIEF.md
# Sixteen-Source Interrupt Collector

This block gathers sixteen asynchronous interrupt request lines into one active-high, level-sensitive interrupt output for a host processor. Each source is brought into the clock domain by a two-flop synchronizer. A rising edge of the synchronized level latches a pending bit. A per-source enable mask gates the pending bits, and the OR of the enabled pending bits drives the output.

The host reaches the block through a small 16-bit register bus with a byte address, a write strobe with write data, and a read strobe with registered read data. Bit n of every register belongs to source n. The host can read the latched pending bits and the live synchronized levels. It can set enable bits through one address and clear them through another. It acknowledges a source by writing a one to its pending bit. Because disabling a source leaves its pending bit alone, the host can mask a line, service it later, and see the output come back as soon as the line is enabled again.

Top module: `irq_collector`

## Requirements
- R1: After reset, every pending bit and every enable bit is zero, `irq_o` is low and `rdata_o` is zero.
- R2: A source that rises and stays high sets its pending bit (bit n for source n) at the third rising clock edge after the change, because of two synchronizer flops and one latch flop. A source that stays high does not set the bit again.
- R3: A read of offset 0x16 returns the pending bits. A write there clears every pending bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: A read of offset 0x18 returns the synchronized, unlatched level of all sixteen sources.
- R5: A write to offset 0x1A sets every enable bit whose write-data bit is 1 and ignores 0 bits. A read of 0x1A returns the enable mask.
- R6: A write to offset 0x1C clears every enable bit whose write-data bit is 1 and ignores 0 bits. A read of 0x1C returns zero and changes no state.
- R7: `irq_o` is high exactly when the bitwise AND of the pending and enable bits is non-zero.
- R8: If a pending bit's rising edge lands in the same cycle as a write of 1 to that bit at 0x16, the bit stays set.
- R9: Disabling a source keeps its pending bit. Enabling a source that is still pending raises `irq_o` in the cycle after the write.
- R10: A read of any other offset returns zero, and a write to any other offset changes no enable or pending bit.
- R11: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves every source disabled with nothing pending, even while sources are held high.
- R12: `rdata_o` shows the selected register in the cycle after `ren_i` is sampled high, and it is zero in the cycle after `ren_i` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Asynchronous interrupt request lines, bit n is source n |
| addr_i | input | 8 | Register byte offset |
| wen_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| ren_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
Two functions of this block can fall in the same cycle: the edge-latching of a pending bit and the host's write-one-to-clear of that same bit. The bench provokes this case directly. It raises a source, then places the acknowledge write so that the write is sampled on the exact edge where the synchronized rise is seen. It then reads back 0x16 and expects the bit to still be set. A long random run toggles sources while it issues overlapping set, clear, acknowledge and unmapped accesses. Every cycle, the bench compares `irq_o` and `rdata_o` against a cycle model kept in the bench, which gives the event priority on every collision.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

    // Byte offsets of the host-visible registers
    localparam logic [7:0] OFS_PEND  = 8'h16;
    localparam logic [7:0] OFS_RAW   = 8'h18;
    localparam logic [7:0] OFS_ENSET = 8'h1A;
    localparam logic [7:0] OFS_ENCLR = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_RAW,
        SEL_ENSET,
        SEL_ENCLR
    } reg_sel_e;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] level_o,
    output logic [N_SRC-1:0] rise_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_line
        logic meta_q, sync_q, last_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= src_i[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign level_o[i] = sync_q;
        assign rise_o[i]  = sync_q & ~last_q;
    end

endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] rise_i,
    input  logic             ack_we_i,
    input  logic [N_SRC-1:0] ack_mask_i,
    output logic [N_SRC-1:0] pend_o
);

    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] clr_bits;

    assign clr_bits = ack_we_i ? ack_mask_i : '0;

    // A new event takes priority over an acknowledge of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_bits) | rise_i;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] bits_i,
    output logic [N_SRC-1:0] en_o
);

    logic [N_SRC-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we_i) begin
            en_q <= en_q | bits_i;
        end else if (clr_we_i) begin
            en_q <= en_q & ~bits_i;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irq_collector_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic [N_SRC-1:0]  wdata_i,
    input  logic              ren_i,
    output logic [N_SRC-1:0]  rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);

    logic [N_SRC-1:0] level, rise, pend_q, en_q, rd_mux, rdata_q;
    reg_sel_e         sel;

    always_comb begin
        if      (addr_i == A_PEND)  sel = SEL_PEND;
        else if (addr_i == A_RAW)   sel = SEL_RAW;
        else if (addr_i == A_ENSET) sel = SEL_ENSET;
        else if (addr_i == A_ENCLR) sel = SEL_ENCLR;
        else                        sel = SEL_NONE;
    end

    irq_sync_edge #(.N_SRC(N_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .level_o (level),
        .rise_o  (rise)
    );

    irq_pending_reg #(.N_SRC(N_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .ack_we_i   (wen_i && sel == SEL_PEND),
        .ack_mask_i (wdata_i),
        .pend_o     (pend_q)
    );

    irq_enable_reg #(.N_SRC(N_SRC)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (wen_i && sel == SEL_ENSET),
        .clr_we_i (wen_i && sel == SEL_ENCLR),
        .bits_i   (wdata_i),
        .en_o     (en_q)
    );

    always_comb begin
        unique case (sel)
            SEL_PEND:  rd_mux = pend_q;
            SEL_RAW:   rd_mux = level;
            SEL_ENSET: rd_mux = en_q;
            SEL_ENCLR: rd_mux = '0;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= ren_i ? rd_mux : '0;
        end
    end

    assign rdata_o = rdata_q;
    assign irq_o   = |(pend_q & en_q);

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wen_i,
    input logic [N_SRC-1:0]  wdata_i,
    input logic              ren_i,
    input logic [N_SRC-1:0]  rdata_o,
    input logic [N_SRC-1:0]  pend_q,
    input logic [N_SRC-1:0]  en_q
);

    logic wr_pend, wr_set, wr_clr;
    assign wr_pend = wen_i && addr_i == ADDR_W'(8'h16);
    assign wr_set  = wen_i && addr_i == ADDR_W'(8'h1A);
    assign wr_clr  = wen_i && addr_i == ADDR_W'(8'h1C);

    // R3: without an acknowledge write, no pending bit falls
    p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R5: a set write turns on every addressed enable bit
    p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

    // R6: a clear write turns off every addressed enable bit
    p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en_q & $past(wdata_i)) == '0));

    // R10: the mask moves only on the two mask addresses
    p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(en_q));

    // R12: read data is zero after an idle read strobe
    p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_i |=> (rdata_o == '0));

endmodule

bind irq_collector irq_collector_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wen_i   (wen_i),
    .wdata_i (wdata_i),
    .ren_i   (ren_i),
    .rdata_o (rdata_o),
    .pend_q  (pend_q),
    .en_q    (en_q)
);

// File: tb/sim_irq_collector.sv
`timescale 1ns/1ps
module sim_irq_collector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wen = 1'b0;
    logic [15:0] wdata = '0;
    logic        ren = 1'b0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_collector u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wen_i(wen),
        .wdata_i(wdata), .ren_i(ren), .rdata_o(rdata), .irq_o(irq)
    );

    // Cycle model built from the requirements
    logic [15:0] m1, m2, m3, mp, men, mrd;

    function automatic logic [15:0] exp_read(input logic [7:0] a, input logic [15:0] p,
                                             input logic [15:0] e, input logic [15:0] raw);
        case (a)
            8'h16:   return p;
            8'h18:   return raw;
            8'h1A:   return e;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; m3 <= '0; mp <= '0; men <= '0; mrd <= '0;
        end else begin
            m1  <= src;
            m2  <= m1;
            m3  <= m2;
            mp  <= (mp & ~((wen && addr == 8'h16) ? wdata : 16'h0)) | (m2 & ~m3);
            if (wen && addr == 8'h1A) men <= men | wdata;
            else if (wen && addr == 8'h1C) men <= men & ~wdata;
            mrd <= ren ? exp_read(addr, mp, men, m2) : 16'h0;
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wen = 1'b1;
        @(negedge clk); wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); addr = a; ren = 1'b1;
        @(negedge clk); ren = 1'b0;
        check(rdata, exp, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({15'b0, irq}, 16'h0, "R1 irq after reset");
        check(rdata, 16'h0, "R1 rdata after reset");
        rd(8'h16, 16'h0000, "R1 pending after reset");
        rd(8'h1A, 16'h0000, "R1 enable after reset");

        // R2 / R4: latch of a rising source
        @(negedge clk); src[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h16, 16'h0008, "R2 pending latched");
        check({15'b0, irq}, 16'h0, "R7 disabled source keeps irq low");
        rd(8'h18, 16'h0008, "R4 raw level");

        // R5 / R7
        wr(8'h1A, 16'h0008);
        check({15'b0, irq}, 16'h1, "R7 enabled pending drives irq");
        rd(8'h1A, 16'h0008, "R5 mask readback");
        wr(8'h1A, 16'h0000);
        rd(8'h1A, 16'h0008, "R5 zero bits ignored");

        // R6
        wr(8'h1C, 16'h0000);
        rd(8'h1A, 16'h0008, "R6 zero bits ignored");
        rd(8'h1C, 16'h0000, "R6 clear address reads zero");
        rd(8'h1A, 16'h0008, "R6 read of clear address has no side effect");

        // R9
        wr(8'h1C, 16'h0008);
        check({15'b0, irq}, 16'h0, "R9 disable drops irq");
        rd(8'h16, 16'h0008, "R9 pending kept while disabled");
        wr(8'h1A, 16'h0008);
        check({15'b0, irq}, 16'h1, "R9 re-enable raises irq next cycle");

        // R3
        wr(8'h16, 16'h0000);
        rd(8'h16, 16'h0008, "R3 zero write keeps pending");
        wr(8'h16, 16'h0008);
        check({15'b0, irq}, 16'h0, "R3 acknowledge drops irq");
        rd(8'h16, 16'h0000, "R3 acknowledge clears pending");
        rd(8'h16, 16'h0000, "R2 held-high source does not retrigger");

        // R10
        wr(8'h20, 16'hFFFF);
        wr(8'h17, 16'hFFFF);
        rd(8'h1A, 16'h0008, "R10 unmapped write leaves mask");
        rd(8'h20, 16'h0000, "R10 unmapped read is zero");
        rd(8'h17, 16'h0000, "R10 odd offset read is zero");

        // R8: rise and acknowledge in the same cycle
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 8'h16; wdata = 16'h0020; wen = 1'b1;
        @(negedge clk); wen = 1'b0;
        rd(8'h16, 16'h0020, "R8 event wins over acknowledge");
        @(negedge clk);
        check(rdata, 16'h0000, "R12 idle read strobe gives zero");

        // R11: global disable and clear with sources held high
        src = 16'hA5AD;
        repeat (4) @(negedge clk);
        wr(8'h1A, 16'hFFFF);
        check({15'b0, irq}, 16'h1, "R7 several sources pending");
        rd(8'h18, 16'hA5AD, "R4 raw pattern");
        wr(8'h1C, 16'hFFFF);
        wr(8'h16, 16'hFFFF);
        check({15'b0, irq}, 16'h0, "R11 irq low after init sequence");
        rd(8'h1A, 16'h0000, "R11 all disabled");
        rd(8'h16, 16'h0000, "R11 nothing pending");

        // Random phase against the cycle model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            check({15'b0, irq}, {15'b0, |(mp & men)}, "R7 random irq");
            check(rdata, mrd, "R12 random read data");
            if ($urandom % 3 == 0) src[$urandom % 16] ^= 1'b1;
            case ($urandom % 6)
                0: addr = 8'h16;
                1: addr = 8'h18;
                2: addr = 8'h1A;
                3: addr = 8'h1C;
                default: addr = 8'($urandom);
            endcase
            wdata = 16'($urandom);
            wen   = ($urandom % 3 == 0);
            ren   = !wen && ($urandom % 2 == 0);
        end
        @(negedge clk); wen = 1'b0; ren = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule